// File: doc/BRIEF.md
# Costas Lock Detector Accumulator

This block decides whether a Costas-loop demodulator has reached lock. Each time the loop presents a valid pair of in-phase and quadrature arm outputs, the block squares both values. It scales each square down by a fixed pre-shift and adds it to its own 32-bit signed accumulator.

After a programmable number of valid samples, the block closes the window. It takes the difference of the two accumulators at full 32-bit width and compares it with a threshold. It updates the lock flag and clears both accumulators. When the loop is locked, the in-phase arm carries the energy and the quadrature arm carries almost none, so the difference is large. When the loop is unlocked, the power spreads over both arms and the difference stays near zero.

Software supplies a single 32-bit control word that packs the window length and the threshold. The accumulators and the last difference are brought out for observation.

Top module: `costas_lock_acc`

## Requirements
- R1: On every clock edge where `arm_valid` is high, the block squares `arm_i` and `arm_q`. Each square is shifted right by 3 on its own, with the fraction dropped, before it is added to its accumulator. The running sums appear on `acc_i_dbg` and `acc_q_dbg` one cycle later.
- R2: A clock edge with `arm_valid` low changes neither accumulator, nor the window position, nor any output, whatever `arm_i` and `arm_q` carry.
- R3: `lock_ctrl[9:0]` is the window length N, counted in valid samples. `lock_ctrl[31:10]` is an unsigned threshold. For example, 0x002EE010 means a threshold of 3000 with a window of 16.
- R4: The Nth valid sample of a window closes it. On the next cycle, `delta_dbg` shows the I sum minus the Q sum, with the closing sample included. The value is a full 32-bit signed result and no low bits are dropped.
- R5: On the same edge that closes a window, both accumulators return to zero. The next window starts with the next valid sample.
- R6: When a window closes, `lock_flag` is set if the difference is strictly greater than the threshold, and cleared otherwise. Between window closings, `lock_flag` holds its value.
- R7: A window length of 0 is treated as 1, so every valid sample closes a window.
- R8: A synchronous active-low reset clears the accumulators, the difference, the lock flag and the window position.
- R9: With 12-bit arm values and windows of up to 1023 samples, neither accumulator overflows. Both stay non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm_valid | input | 1 | Marks a valid arm sample pair |
| arm_i | input | 12 | Signed in-phase arm value |
| arm_q | input | 12 | Signed quadrature arm value |
| lock_ctrl | input | 32 | Threshold in [31:10], window length in [9:0] |
| lock_flag | output | 1 | Lock decision from the last closed window |
| acc_i_dbg | output | 32 | Running in-phase square sum |
| acc_q_dbg | output | 32 | Running quadrature square sum |
| delta_dbg | output | 32 | Signed difference from the last closed window |

## Verification
Every result is registered exactly once after the sampling edge. The accumulators, `delta_dbg` and `lock_flag` therefore all show the effect of a valid sample one cycle after the edge that takes it in. The bench drives inputs on the falling edge and reads outputs on the next falling edge, which comes half a period after the capturing edge. It reads the accumulators after a single sample partway through a window, and reads the difference, the flag and the cleared sums right after the closing sample. The expected difference is N times the difference of the individually shifted squares, which the bench computes from R1 and R4.

// File: rtl/costas_lock_pkg.sv
// Package: shared widths for the Costas lock detector.
// Assumes the control word is exactly CNT_W + THR_W bits wide.
package costas_lock_pkg;
    localparam int ARM_W     = 12;
    localparam int ACC_W     = 32;
    localparam int PRE_SHIFT = 3;
    localparam int CNT_W     = 10;
    localparam int CTRL_W    = 32;
    localparam int THR_W     = CTRL_W - CNT_W;

    typedef struct packed {
        logic [THR_W-1:0] threshold;
        logic [CNT_W-1:0] window;
    } lock_ctrl_t;
endpackage

// File: rtl/cld_square_scale.sv
// Squares a signed arm value and divides it by 2**PRE_SHIFT (floor).
// Assumes ACC_W is wide enough to hold (2**(ARM_W-1))**2 exactly.
module cld_square_scale #(
    parameter int ARM_W     = 12,
    parameter int ACC_W     = 32,
    parameter int PRE_SHIFT = 3
) (
    input  logic signed [ARM_W-1:0] sample,
    output logic signed [ACC_W-1:0] term
);
    localparam int EXT_W = ACC_W - ARM_W;

    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] sq;

    // Sign-extend, square, and pre-scale the non-negative square.
    always_comb begin
        ext  = {{EXT_W{sample[ARM_W-1]}}, sample};
        sq   = ext * ext;
        term = sq >>> PRE_SHIFT;
    end
endmodule

// File: rtl/cld_window_ctr.sv
// Counts valid samples and flags the sample that closes a window.
// Assumes a window length of 0 means 1. If the length shrinks mid-window,
// the next valid sample closes the window.
module cld_window_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [CNT_W-1:0] win_len,
    output logic             win_end
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   taken;
    logic [CNT_W:0]   len_eff;

    // Decide whether the current valid sample completes the window.
    always_comb begin
        taken   = {1'b0, cnt_q} + 1'b1;
        len_eff = (win_len == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, win_len};
        win_end = valid && (taken >= len_eff);
    end

    // Advance the sample count, restarting at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (valid) begin
            cnt_q <= win_end ? '0 : taken[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/cld_arm_acc.sv
// Accumulates scaled squares of one arm and clears at window end.
// Exposes the sum including the current term for the window decision.
module cld_arm_acc #(
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid,
    input  logic                    clear,
    input  logic signed [ACC_W-1:0] term,
    output logic signed [ACC_W-1:0] sum_now,
    output logic signed [ACC_W-1:0] acc
);
    // Running sum including the sample presented this cycle.
    always_comb sum_now = acc + term;

    // Register the sum, or clear it when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (valid) begin
            acc <= clear ? '0 : sum_now;
        end
    end
endmodule

// File: rtl/cld_lock_decide.sv
// Forms the I-minus-Q difference at window end and compares it, as a signed
// value, with the zero-extended unsigned threshold. Holds both between windows.
module cld_lock_decide #(
    parameter int ACC_W = 32,
    parameter int THR_W = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_end,
    input  logic signed [ACC_W-1:0] sum_i,
    input  logic signed [ACC_W-1:0] sum_q,
    input  logic [THR_W-1:0]        threshold,
    output logic signed [ACC_W-1:0] delta,
    output logic                    lock
);
    localparam int PAD_W = ACC_W - THR_W;

    logic signed [ACC_W-1:0] diff;
    logic signed [ACC_W-1:0] thr_ext;

    // Full-width difference and threshold extension.
    always_comb begin
        diff    = sum_i - sum_q;
        thr_ext = {{PAD_W{1'b0}}, threshold};
    end

    // Capture the difference and the lock decision at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delta <= '0;
            lock  <= 1'b0;
        end else if (win_end) begin
            delta <= diff;
            lock  <= (diff > thr_ext);
        end
    end
endmodule

// File: rtl/costas_lock_acc.sv
// Top level: Costas lock detector. Sums the pre-scaled squares of both arms
// over a window of valid samples and sets the lock flag when the I sum exceeds
// the Q sum by more than a threshold. Both values come from one control word.
module costas_lock_acc
    import costas_lock_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arm_valid,
    input  logic signed [ARM_W-1:0] arm_i,
    input  logic signed [ARM_W-1:0] arm_q,
    input  logic [CTRL_W-1:0]       lock_ctrl,
    output logic                    lock_flag,
    output logic [ACC_W-1:0]        acc_i_dbg,
    output logic [ACC_W-1:0]        acc_q_dbg,
    output logic [ACC_W-1:0]        delta_dbg
);
    lock_ctrl_t ctrl;
    logic       win_end;

    logic signed [ARM_W-1:0] arm_sample [2];
    logic signed [ACC_W-1:0] term       [2];
    logic signed [ACC_W-1:0] sum_now    [2];
    logic signed [ACC_W-1:0] acc        [2];
    logic signed [ACC_W-1:0] delta;

    // Unpack the control word and route the arm inputs.
    always_comb begin
        ctrl          = lock_ctrl_t'(lock_ctrl);
        arm_sample[0] = arm_i;
        arm_sample[1] = arm_q;
    end

    cld_window_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (arm_valid),
        .win_len (ctrl.window),
        .win_end (win_end)
    );

    for (genvar a = 0; a < 2; a++) begin : g_arm
        cld_square_scale #(
            .ARM_W(ARM_W), .ACC_W(ACC_W), .PRE_SHIFT(PRE_SHIFT)
        ) u_sq (
            .sample (arm_sample[a]),
            .term   (term[a])
        );

        cld_arm_acc #(.ACC_W(ACC_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid   (arm_valid),
            .clear   (win_end),
            .term    (term[a]),
            .sum_now (sum_now[a]),
            .acc     (acc[a])
        );
    end

    cld_lock_decide #(.ACC_W(ACC_W), .THR_W(THR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end   (win_end),
        .sum_i     (sum_now[0]),
        .sum_q     (sum_now[1]),
        .threshold (ctrl.threshold),
        .delta     (delta),
        .lock      (lock_flag)
    );

    // Drive the debug outputs.
    always_comb begin
        acc_i_dbg = acc[0];
        acc_q_dbg = acc[1];
        delta_dbg = delta;
    end
endmodule

// File: rtl/costas_lock_acc_chk.sv
// Checker: temporal properties of the lock detector, bound to the top module.
module costas_lock_acc_chk #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_valid,
    input logic             win_end,
    input logic             lock_flag,
    input logic [ACC_W-1:0] acc_i_dbg,
    input logic [ACC_W-1:0] acc_q_dbg,
    input logic [ACC_W-1:0] delta_dbg
);
    // R2: an idle cycle leaves both sums unchanged.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_valid |=> ($stable(acc_i_dbg) && $stable(acc_q_dbg)));

    // R5: both sums are zero right after a window closes.
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (acc_i_dbg == '0 && acc_q_dbg == '0));

    // R6: the flag and the difference move only at window ends.
    p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> ($stable(lock_flag) && $stable(delta_dbg)));

    // R8: reset leaves everything cleared.
    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> (!lock_flag && acc_i_dbg == '0 && acc_q_dbg == '0 && delta_dbg == '0));

    // R9: sums of squares never wrap into negative values.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm_valid |=> (!acc_i_dbg[ACC_W-1] && !acc_q_dbg[ACC_W-1]));
endmodule

bind costas_lock_acc costas_lock_acc_chk #(.ACC_W(costas_lock_pkg::ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_valid (arm_valid),
    .win_end   (win_end),
    .lock_flag (lock_flag),
    .acc_i_dbg (acc_i_dbg),
    .acc_q_dbg (acc_q_dbg),
    .delta_dbg (delta_dbg)
);

// File: tb/costas_lock_acc_bench.sv
`timescale 1ns/1ps
// Bench: walks a table of windows, then runs directed reset and corner tests.
module costas_lock_acc_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               arm_valid = 1'b0;
    logic signed [11:0] arm_i = '0;
    logic signed [11:0] arm_q = '0;
    logic [31:0]        lock_ctrl = '0;
    logic               lock_flag;
    logic [31:0]        acc_i_dbg;
    logic [31:0]        acc_q_dbg;
    logic [31:0]        delta_dbg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    costas_lock_acc u_costas_lock_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_valid (arm_valid),
        .arm_i     (arm_i),
        .arm_q     (arm_q),
        .lock_ctrl (lock_ctrl),
        .lock_flag (lock_flag),
        .acc_i_dbg (acc_i_dbg),
        .acc_q_dbg (acc_q_dbg),
        .delta_dbg (delta_dbg)
    );

    // Table columns: I, Q, window length, threshold, expected lock.
    localparam int NV = 9;
    localparam int VI  [NV] = '{2047, 1000, -2048, 20, 40, 40, 0,    3, 100};
    localparam int VQ  [NV] = '{0,    1000, 5,     0,  0,  0,  2047, 2, 0};
    localparam int VW  [NV] = '{16,   16,   1023,  16, 15, 16, 16,   5, 0};
    localparam int VT  [NV] = '{3000, 3000, 3000,  3000, 3000, 3000, 3000, 4, 1000};
    localparam bit VL  [NV] = '{1'b1, 1'b0, 1'b1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

    function automatic longint term(input int x);
        return (longint'(x) * longint'(x)) >>> 3;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One valid sample; returns at the falling edge after it is captured.
    task automatic push(input int i, input int q);
        arm_valid = 1'b1;
        arm_i = 12'(i);
        arm_q = 12'(q);
        @(negedge clk);
        arm_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset lock", longint'(lock_flag), 0);
        chk("R8 reset acc_i", longint'(acc_i_dbg), 0);
        chk("R8 reset delta", longint'(delta_dbg), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            automatic int weff = (VW[v] == 0) ? 1 : VW[v];
            automatic longint exp_d = longint'(weff) * (term(VI[v]) - term(VQ[v]));
            lock_ctrl = (32'(VT[v]) << 10) | 32'(VW[v]);
            for (int s = 0; s < weff; s++) begin
                push(VI[v], VQ[v]);
                if (s == 0 && weff > 1) begin
                    chk("R1 acc_i after one sample", longint'(acc_i_dbg), term(VI[v]));
                    chk("R1 acc_q after one sample", longint'(acc_q_dbg), term(VQ[v]));
                end
                if (s % 3 == 2) @(negedge clk);
            end
            chk("R4 delta", longint'($signed(delta_dbg)), exp_d);
            chk("R6 lock vs table", longint'(lock_flag), longint'(VL[v]));
            chk("R6 lock vs rule", longint'(lock_flag), longint'(exp_d > VT[v]));
            chk("R5 acc_i cleared", longint'(acc_i_dbg), 0);
            chk("R5 acc_q cleared", longint'(acc_q_dbg), 0);
            if (v == 2) chk("R9 large window sum positive", longint'(delta_dbg[31]), 0);
            if (v == 8) chk("R7 zero length closes each sample", longint'(delta_dbg), term(100));
        end

        // R3: the literal control word packs threshold 3000 with a window of 16.
        lock_ctrl = 32'h002EE010;
        for (int s = 0; s < 16; s++) push(40, 0);
        chk("R3 packed word delta", longint'(delta_dbg), 3200);
        chk("R3 packed word lock", longint'(lock_flag), 1);

        // R2: idle cycles with busy arm values leave the sums untouched.
        push(7, 3);
        arm_i = 12'sd2047;
        arm_q = 12'sd2047;
        repeat (4) @(negedge clk);
        chk("R2 idle acc_i", longint'(acc_i_dbg), term(7));
        chk("R2 idle acc_q", longint'(acc_q_dbg), term(3));

        // R6: a partial unlocked window does not disturb the held flag.
        for (int s = 0; s < 10; s++) push(500, 500);
        chk("R6 lock held mid-window", longint'(lock_flag), 1);
        chk("R6 delta held mid-window", longint'(delta_dbg), 3200);

        // R8: reset partway through a window restarts the count.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 mid reset lock", longint'(lock_flag), 0);
        chk("R8 mid reset acc_i", longint'(acc_i_dbg), 0);
        for (int s = 0; s < 15; s++) push(40, 0);
        chk("R8 no early close", longint'(delta_dbg), 0);
        push(40, 0);
        chk("R8 full window after reset", longint'(delta_dbg), 3200);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule